// File: doc/BRIEF.md
# Millisecond Periodic Interrupt Timer

This block produces a periodic interrupt for a processor. It runs from a fixed-frequency reference clock, divides that clock down to a one-millisecond enable pulse, and counts those pulses. When a programmed period of (reload + 1) milliseconds has elapsed, the interrupt line goes high and the next period starts at once. The reload value is nine bits wide, so the rate can be set anywhere from 1000 Hz down to about 1.95 Hz.

Software uses two registers on a 32-bit register port. A write to the reload register stores a new period, clears the interrupt and starts a fresh period from zero. A read of the count register returns zero and acknowledges the interrupt. The interrupt is a level: it stays high until it is acknowledged or the reload register is written, and extra expirations while it is high are not counted.

Top module: `ms_interval_timer`

## Requirements
- R1: A write to byte address 0x228 stores bits 8:0 of the write data as the reload value and ignores bits 31:9. A read of 0x228 returns the reload value in bits 8:0, with bits 31:9 zero.
- R2: The first expiry after a restart sets `irq` on the clock edge (reload+1)*TICK cycles after the restarting edge, where TICK = CLK_HZ/1000. Later expiries follow every (reload+1)*TICK cycles.
- R3: A read of byte address 0x230 returns 0 and drives `irq` low on the same edge, unless an expiry falls on that edge (see R7).
- R4: A write to 0x228 drives `irq` low on that edge and restarts both the millisecond prescaler and the period count from zero. An expiry that would fall on that edge is dropped.
- R5: Once set, `irq` stays high until a count read or a reload write, whatever number of further periods expire.
- R6: A synchronous active-high `rst` sets the reload value to 0, `irq` to 0 and `bus_rdata` to 0, and starts a period. With reload 0, the first expiry comes TICK cycles after reset is released.
- R7: If a count read and an expiry fall on the same edge, `irq` is high after that edge.
- R8: Read data appears on `bus_rdata` one cycle after the read strobe and is 0 in every other cycle. Address bits 1:0 are ignored. Reads of any other address return 0. Writes to any other address change nothing.
- R9: The internal millisecond pulse occurs exactly TICK cycles after reset, after a reload write, or after the previous pulse.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock at CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 14 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Periodic interrupt level |

## Verification
The bound checker checks on every cycle that the millisecond pulse keeps its TICK spacing, that an expiry only happens on a pulse and always leaves `irq` set, that a reload write or an unopposed count read leaves `irq` low, that `irq` holds while nothing clears it, and that read data for the count and reload registers has the right shape. Only the bench scenarios can show that the full period length equals (reload+1)*TICK for several reload values, that a restart partway through a period measures from the write, that masking of the upper write bits and ignored addresses has no visible effect, and that a read coinciding with an expiry keeps the interrupt. A behavioural countdown model in the bench is compared against `irq` and `bus_rdata` on every clock.

// File: rtl/mit_pkg.sv
package mit_pkg;
  localparam int unsigned ADDR_W = 14;
  // Register offsets are part of the bus contract; bits 1:0 are not decoded.
  localparam logic [ADDR_W-1:0] RELOAD_OFS = 14'h228;
  localparam logic [ADDR_W-1:0] COUNT_OFS  = 14'h230;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_COUNT  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/mit_prescaler.sv
module mit_prescaler #(
  parameter int unsigned DIV = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      logic unused_pins;
      assign unused_pins = ^{clk, rst, restart};
      assign tick = 1'b1;
    end else begin : g_div
      localparam int unsigned W = $clog2(DIV);
      localparam logic [W-1:0] LAST = W'(DIV - 1);
      logic [W-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst || restart) begin
          cnt <= '0;
        end else if (cnt == LAST) begin
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end

      assign tick = (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/mit_period_counter.sv
module mit_period_counter #(
  parameter int unsigned RELOAD_W = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                restart,
  input  logic                tick,
  input  logic [RELOAD_W-1:0] reload,
  output logic                expire
);
  logic [RELOAD_W-1:0] ms_cnt;
  logic                at_end;

  assign at_end = (ms_cnt == reload);
  // A restart on the same edge takes priority and drops the expiry.
  assign expire = tick && at_end && !restart;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      ms_cnt <= '0;
    end else if (tick) begin
      ms_cnt <= at_end ? '0 : ms_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mit_regs.sv
module mit_regs
  import mit_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned RELOAD_W = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [RELOAD_W-1:0] reload_q,
  output logic                reload_wr,
  output logic                count_rd,
  output logic [DATA_W-1:0]   rdata
);
  reg_sel_e sel;
  logic     unused_bits;

  assign unused_bits = ^{wdata[DATA_W-1:RELOAD_W], addr[1:0]};

  always_comb begin
    if (addr[ADDR_W-1:2] == RELOAD_OFS[ADDR_W-1:2]) begin
      sel = SEL_RELOAD;
    end else if (addr[ADDR_W-1:2] == COUNT_OFS[ADDR_W-1:2]) begin
      sel = SEL_COUNT;
    end else begin
      sel = SEL_NONE;
    end
  end

  assign reload_wr = wr_en && (sel == SEL_RELOAD);
  assign count_rd  = rd_en && (sel == SEL_COUNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      rdata    <= '0;
    end else begin
      if (reload_wr) begin
        reload_q <= wdata[RELOAD_W-1:0];
      end
      // The count register always reads as zero; only reload is visible.
      if (rd_en && (sel == SEL_RELOAD)) begin
        rdata <= DATA_W'(reload_q);
      end else begin
        rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/ms_interval_timer.sv
module ms_interval_timer
  import mit_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned RELOAD_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int unsigned TICK_CYCLES = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;

  logic [RELOAD_W-1:0] reload_q;
  logic                reload_wr;
  logic                count_rd;
  logic                ms_tick;
  logic                expire;

  mit_regs #(
    .DATA_W   (DATA_W),
    .RELOAD_W (RELOAD_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (bus_wr),
    .rd_en     (bus_rd),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .reload_q  (reload_q),
    .reload_wr (reload_wr),
    .count_rd  (count_rd),
    .rdata     (bus_rdata)
  );

  mit_prescaler #(
    .DIV (TICK_CYCLES)
  ) u_pre (
    .clk     (clk),
    .rst     (rst),
    .restart (reload_wr),
    .tick    (ms_tick)
  );

  mit_period_counter #(
    .RELOAD_W (RELOAD_W)
  ) u_period (
    .clk     (clk),
    .rst     (rst),
    .restart (reload_wr),
    .tick    (ms_tick),
    .reload  (reload_q),
    .expire  (expire)
  );

  // Reload write clears; a new expiry outranks an acknowledge on the same edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else if (reload_wr) begin
      irq <= 1'b0;
    end else if (expire) begin
      irq <= 1'b1;
    end else if (count_rd) begin
      irq <= 1'b0;
    end
  end
endmodule

// File: rtl/mit_checker.sv
module mit_checker
  import mit_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 50000,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned RELOAD_W    = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic              ms_tick,
  input logic              expire
);
  localparam int unsigned GW = $clog2(TICK_CYCLES + 1) + 1;

  logic wr_reload;
  logic rd_count;
  logic rd_reload;
  logic [GW-1:0] gap;

  assign wr_reload = bus_wr && (bus_addr[ADDR_W-1:2] == RELOAD_OFS[ADDR_W-1:2]);
  assign rd_count  = bus_rd && (bus_addr[ADDR_W-1:2] == COUNT_OFS[ADDR_W-1:2]);
  assign rd_reload = bus_rd && (bus_addr[ADDR_W-1:2] == RELOAD_OFS[ADDR_W-1:2]);

  // Cycles since reset, reload write or previous millisecond pulse.
  always_ff @(posedge clk) begin
    if (rst || wr_reload || ms_tick) begin
      gap <= '0;
    end else begin
      gap <= gap + 1'b1;
    end
  end

  p_tick_spacing_r9: assert property (@(posedge clk) disable iff (rst)
    ms_tick |-> (gap == GW'(TICK_CYCLES - 1)));

  p_expire_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
    expire |-> ms_tick);

  p_expire_sets_r2: assert property (@(posedge clk) disable iff (rst)
    expire |=> irq);

  p_read_ack_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_count && !expire && !wr_reload) |=> !irq);

  p_count_zero_r3: assert property (@(posedge clk) disable iff (rst)
    rd_count |=> (bus_rdata == '0));

  p_reload_clears_r4: assert property (@(posedge clk) disable iff (rst)
    wr_reload |=> !irq);

  p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (irq && !rd_count && !wr_reload) |=> irq);

  p_coincide_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_count && expire) |=> irq);

  p_readback_width_r1: assert property (@(posedge clk) disable iff (rst)
    rd_reload |=> (bus_rdata[DATA_W-1:RELOAD_W] == '0));

  p_idle_rdata_r8: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
endmodule

bind ms_interval_timer mit_checker #(
  .TICK_CYCLES (TICK_CYCLES),
  .DATA_W      (DATA_W),
  .RELOAD_W    (RELOAD_W)
) u_mit_checker (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .ms_tick   (ms_tick),
  .expire    (expire)
);

// File: tb/tb_ms_interval_timer.sv
module tb_ms_interval_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 8000;
  localparam int TICK       = CLK_HZ / 1000;
  localparam int RELOAD_A   = 14'h228;
  localparam int COUNT_A    = 14'h230;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [13:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  string cur_req = "R6";

  // Reference model state
  int  m_rel = 0;
  int  m_left = TICK;
  bit  m_irq = 0;
  int  m_rdata = 0;
  bit  started = 0;
  int  cyc = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ms_interval_timer #(.CLK_HZ(CLK_HZ)) dut (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    started = 1;
    if (rst) begin
      m_rel = 0; m_left = TICK; m_irq = 0; m_rdata = 0;
    end else begin
      m_rdata = (bus_rd && (bus_addr >> 2) == (RELOAD_A >> 2)) ? m_rel : 0;
      if (bus_wr && (bus_addr >> 2) == (RELOAD_A >> 2)) begin
        m_rel = bus_wdata & 32'h1FF;
        m_left = (m_rel + 1) * TICK;
        m_irq = 0;
      end else begin
        m_left--;
        if (m_left == 0) begin
          m_left = (m_rel + 1) * TICK;
          m_irq = 1;
        end else if (bus_rd && (bus_addr >> 2) == (COUNT_A >> 2)) begin
          m_irq = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      check({cur_req, " irq"}, int'(irq), int'(m_irq));
      check({cur_req, " rdata"}, int'(bus_rdata), m_rdata);
    end
  end

  task automatic bus_write(int a, int d);
    @(negedge clk); #1;
    bus_wr = 1; bus_addr = 14'(a); bus_wdata = d;
    @(negedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic bus_read(int a, output int d);
    @(negedge clk); #1;
    bus_rd = 1; bus_addr = 14'(a);
    @(negedge clk);
    d = bus_rdata;
    #1 bus_rd = 0;
  endtask

  task automatic wait_rise(output int t);
    while (irq !== 1'b1) @(negedge clk);
    t = cyc;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int d, t0, t1, t2, seen;
    // R6: reset state
    idle(3);
    check("R6 irq in reset", int'(irq), 0);
    check("R6 rdata in reset", int'(bus_rdata), 0);
    #1 rst = 0;
    t0 = cyc;
    wait_rise(t1);
    check("R6 first expiry after reset", t1 - t0, TICK);
    bus_read(RELOAD_A, d);
    check("R6 reload after reset", d, 0);

    // R3: count read returns zero and acknowledges
    cur_req = "R3";
    bus_read(COUNT_A, d);
    check("R3 count reads zero", d, 0);

    // R1: only low nine bits stored
    cur_req = "R1";
    bus_write(RELOAD_A, 32'hFFFF_FE03);
    t0 = cyc;
    bus_read(RELOAD_A, d);
    check("R1 reload readback", d, 3);

    // R2: period lengths
    cur_req = "R2";
    wait_rise(t1);
    check("R2 first period reload 3", t1 - t0, 4 * TICK);
    bus_read(COUNT_A, d);
    wait_rise(t2);
    check("R2 second period reload 3", t2 - t1, 4 * TICK);

    // R5: sticky level across several expirations
    cur_req = "R5";
    idle(12 * TICK);
    check("R5 irq held", int'(irq), 1);

    // R4: reload write clears and restarts mid-period
    cur_req = "R4";
    bus_read(COUNT_A, d);
    idle(TICK + 3);
    bus_write(RELOAD_A, 1);
    t0 = cyc;
    check("R4 irq low after reload write", int'(irq), 0);
    wait_rise(t1);
    check("R4 restarted period", t1 - t0, 2 * TICK);

    // R7: continuous acknowledges across expiries keep the new event
    cur_req = "R7";
    bus_write(RELOAD_A, 0);
    seen = 0;
    @(negedge clk); #1;
    bus_rd = 1; bus_addr = COUNT_A;
    for (int i = 0; i < 4 * TICK; i++) begin
      @(negedge clk);
      if (irq === 1'b1) seen++;
    end
    #1 bus_rd = 0;
    check("R7 expiries visible during reads", seen, 4);

    // R8: aliases and unmapped addresses
    cur_req = "R8";
    bus_write(RELOAD_A + 2, 7);
    bus_read(RELOAD_A + 1, d);
    check("R8 low address bits ignored", d, 7);
    bus_write(14'h22C, 9);
    bus_read(RELOAD_A, d);
    check("R8 write elsewhere ignored", d, 7);
    bus_read(14'h100, d);
    check("R8 other address reads zero", d, 0);

    // R9 / R2: large reload, full period
    cur_req = "R9";
    bus_write(RELOAD_A, 511);
    t0 = cyc;
    wait_rise(t1);
    check("R9 period reload 511", t1 - t0, 512 * TICK);

    // R6: reset mid-run restores defaults
    cur_req = "R6";
    @(negedge clk); #1 rst = 1;
    idle(2);
    #1 rst = 0;
    bus_read(RELOAD_A, d);
    check("R6 reload cleared by reset", d, 0);
    idle(3 * TICK);
    finish_run();
  end
endmodule